// File: doc/BRIEF.md
# Crossbar Connection Configuration Matrix

This block stores the connection settings of a bidirectional crossbar switch with a parameterised number of ports. The settings are held in a square array of one-bit cells, indexed by a row port number and a column port number. A cell set to one means that the two ports it names are joined. The analog switch fabric reads these bits. Here they are only stored, changed and queried.

A single-cycle configure port takes a strobe, a 3-bit control code, a row number and a column number. Control bit 2 selects fast configuration and must be zero for anything to happen. Bit 0 is the value written to the addressed cell. When bit 1 is zero, every other cell in the addressed row is cleared in the same clock edge. A caller therefore replaces the existing connection of an output port with a new one in one operation, with no separate break step. A combinational query port reports whether two ports are joined, taking either of the two mirrored cells into account. A row readout exposes one stored row at a time.

Top module: `xbar_cfg_matrix`

## Requirements
- R1: While `rst_n` is low, every cell is cleared at each rising clock edge. After reset, every row reads back as zero and no pair of ports reports a connection.
- R2: With `cfg_valid` high, code 3'b011 and both addresses no greater than `HI_PORT`, cell (row, col) becomes 1 at the next rising edge. All other cells keep their values.
- R3: With `cfg_valid` high, code 3'b010 and both addresses in range, cell (row, col) becomes 0. All other cells keep their values.
- R4: With `cfg_valid` high, code 3'b001 and both addresses in range, the addressed row becomes exactly one set bit at position col. Other rows keep their values.
- R5: With `cfg_valid` high, code 3'b000 and both addresses in range, the whole addressed row becomes zero. Other rows keep their values.
- R6: A strobed operation with control bit 2 set (codes 3'b1xx) changes no cell and never raises `cfg_err`, whatever its addresses.
- R7: A strobed operation with control bit 2 clear and a row or column above `HI_PORT` changes no cell. It drives `cfg_err` high for exactly the one cycle after its clock edge. An address equal to `HI_PORT` is accepted.
- R8: When `cfg_valid` is low, no cell changes and `cfg_err` is low in the following cycle.
- R9: `qry_linked` equals cell(a,b) OR cell(b,a) for the current stored state, and is 0 when either query port number is above `HI_PORT`. During the cycle in which a write is presented, it shows the state from before that write. It shows the new state only after the clock edge.
- R10: `rd_bits` shows, combinationally, stored row `rd_row`, with bit k being cell (rd_row, k).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous active-low reset, clears all cells |
| cfg_valid | input | 1 | Strobe: the configure operation is taken at this edge |
| cfg_ctrl | input | 3 | Control code: bit 2 fast-configure select (0 = act), bit 1 keep rest of row (0 = clear row), bit 0 cell value |
| cfg_row | input | AW | Row port number of the cell to write |
| cfg_col | input | AW | Column port number of the cell to write |
| cfg_err | output | 1 | One-cycle pulse after a fast-configure operation with an out-of-range address |
| qry_a | input | AW | First port number of the connection query |
| qry_b | input | AW | Second port number of the connection query |
| qry_linked | output | 1 | High when the two queried ports are joined |
| rd_row | input | AW | Row selected for readout |
| rd_bits | output | NPORTS | Contents of the selected row |

## Verification
A write and a connection query on the same pair of ports can occur in the same cycle. In that cycle the query must still report the state from before the write, and it must report the new state only after the edge. The bench provokes this on every driven cycle: it points the query at the pair being written, samples `qry_linked` just before the rising edge, and compares it with the model's old state. The scoreboard then compares the same query, taken just after the edge, with the updated model. The mirrored pair (b,a) is queried as well, so a connection made from either side is seen.

// File: rtl/xbar_cfg_pkg.sv
// Package: shared control-code layout and decoded command type for the
// crossbar configuration matrix. Assumes a 3-bit control code.
package xbar_cfg_pkg;

    localparam int CTL_W        = 3;
    localparam int CTL_SEL_BIT  = 2;  // must be 0 for a fast-configure op
    localparam int CTL_KEEP_BIT = 1;  // 0 = clear rest of the row
    localparam int CTL_VAL_BIT  = 0;  // value written into the cell

    typedef struct packed {
        logic wr_en;     // accepted write this cycle
        logic set_val;   // value for the addressed cell
        logic row_wipe;  // clear the other cells of the row
        logic addr_bad;  // fast-configure op with an out-of-range address
    } cfg_cmd_t;

endpackage

// File: rtl/xbar_cfg_decode.sv
// Module: xbar_cfg_decode
// Turns the strobe, control code and addresses into a decoded command.
// Assumes HI_PORT fits in AW bits. Purely combinational.
module xbar_cfg_decode
    import xbar_cfg_pkg::*;
#(
    parameter int AW      = 4,
    parameter int HI_PORT = 13
) (
    input  logic             valid_i,
    input  logic [CTL_W-1:0] ctrl_i,
    input  logic [AW-1:0]    row_i,
    input  logic [AW-1:0]    col_i,
    output cfg_cmd_t         cmd_o
);

    localparam logic [AW-1:0] HI_ADDR = AW'(HI_PORT);

    logic fast_op;
    logic in_range;

    // Classify the operation and check both addresses against the limit.
    always_comb begin
        fast_op        = valid_i && !ctrl_i[CTL_SEL_BIT];
        in_range       = (row_i <= HI_ADDR) && (col_i <= HI_ADDR);
        cmd_o.wr_en    = fast_op && in_range;
        cmd_o.set_val  = ctrl_i[CTL_VAL_BIT];
        cmd_o.row_wipe = !ctrl_i[CTL_KEEP_BIT];
        cmd_o.addr_bad = fast_op && !in_range;
    end

endmodule

// File: rtl/xbar_cell_row.sv
// Module: xbar_cell_row
// One row of connection cells. On a selected write it either updates a
// single column or replaces the whole row with only that column's value.
// Assumes col_hot_i is one-hot when we_i is high.
module xbar_cell_row #(
    parameter int NPORTS = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we_i,
    input  logic [NPORTS-1:0] col_hot_i,
    input  logic              set_val_i,
    input  logic              row_wipe_i,
    output logic [NPORTS-1:0] bits_o
);

    logic [NPORTS-1:0] bits_q;
    logic [NPORTS-1:0] bits_nxt;

    // Next row value for a write: whole-row replace or single-bit update.
    always_comb begin
        if (row_wipe_i)
            bits_nxt = set_val_i ? col_hot_i : '0;
        else if (set_val_i)
            bits_nxt = bits_q | col_hot_i;
        else
            bits_nxt = bits_q & ~col_hot_i;
    end

    // Row storage with synchronous active-low clear.
    always_ff @(posedge clk) begin
        if (!rst_n)
            bits_q <= '0;
        else if (we_i)
            bits_q <= bits_nxt;
    end

    assign bits_o = bits_q;

endmodule

// File: rtl/xbar_link_query.sv
// Module: xbar_link_query
// Combinational readout: symmetric connection test between two ports and
// a single-row view. Port numbers above HI_PORT never report a link.
module xbar_link_query #(
    parameter int NPORTS  = 16,
    parameter int AW      = 4,
    parameter int HI_PORT = 13
) (
    input  logic [NPORTS-1:0][NPORTS-1:0] cells_i,
    input  logic [AW-1:0]                 qa_i,
    input  logic [AW-1:0]                 qb_i,
    input  logic [AW-1:0]                 rd_row_i,
    output logic                          linked_o,
    output logic [NPORTS-1:0]             rd_bits_o
);

    localparam logic [AW-1:0] HI_ADDR  = AW'(HI_PORT);
    localparam logic [AW-1:0] LAST_ROW = AW'(NPORTS - 1);

    // Either mirrored cell joins the two ports.
    always_comb begin
        if (qa_i <= HI_ADDR && qb_i <= HI_ADDR)
            linked_o = cells_i[qa_i][qb_i] | cells_i[qb_i][qa_i];
        else
            linked_o = 1'b0;
    end

    // Row view, zero for indices past the last stored row.
    always_comb begin
        if (rd_row_i <= LAST_ROW)
            rd_bits_o = cells_i[rd_row_i];
        else
            rd_bits_o = '0;
    end

endmodule

// File: rtl/xbar_cfg_matrix.sv
// Module: xbar_cfg_matrix (top)
// Connection-bit store of an NPORTS crossbar. Accepts at most one
// fast-configure operation per cycle, reports address errors one cycle
// later, and answers symmetric connection queries combinationally.
// Assumes HI_PORT < NPORTS <= 2**AW.
module xbar_cfg_matrix
    import xbar_cfg_pkg::*;
#(
    parameter int NPORTS  = 16,
    parameter int AW      = 4,
    parameter int HI_PORT = 13
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_valid,
    input  logic [2:0]        cfg_ctrl,
    input  logic [AW-1:0]     cfg_row,
    input  logic [AW-1:0]     cfg_col,
    output logic              cfg_err,
    input  logic [AW-1:0]     qry_a,
    input  logic [AW-1:0]     qry_b,
    output logic              qry_linked,
    input  logic [AW-1:0]     rd_row,
    output logic [NPORTS-1:0] rd_bits
);

    localparam logic [AW-1:0] LAST_ROW = AW'(NPORTS - 1);

    cfg_cmd_t                      cmd;
    logic [NPORTS-1:0]             col_hot;
    logic [NPORTS-1:0]             row_hit;
    logic [NPORTS-1:0][NPORTS-1:0] cell_q;
    logic                          err_q;

    xbar_cfg_decode #(
        .AW      (AW),
        .HI_PORT (HI_PORT)
    ) u_decode (
        .valid_i (cfg_valid),
        .ctrl_i  (cfg_ctrl),
        .row_i   (cfg_row),
        .col_i   (cfg_col),
        .cmd_o   (cmd)
    );

    // One-hot column select for the addressed cell.
    always_comb begin
        col_hot = '0;
        if (cfg_col <= LAST_ROW)
            col_hot[cfg_col] = 1'b1;
    end

    for (genvar g = 0; g < NPORTS; g++) begin : g_row
        // Row g is written only by an accepted operation addressing it.
        assign row_hit[g] = cmd.wr_en && (cfg_row == AW'(g));

        xbar_cell_row #(
            .NPORTS (NPORTS)
        ) u_row (
            .clk        (clk),
            .rst_n      (rst_n),
            .we_i       (row_hit[g]),
            .col_hot_i  (col_hot),
            .set_val_i  (cmd.set_val),
            .row_wipe_i (cmd.row_wipe),
            .bits_o     (cell_q[g])
        );
    end

    // Register the rejection so it appears as a one-cycle pulse.
    always_ff @(posedge clk) begin
        if (!rst_n)
            err_q <= 1'b0;
        else
            err_q <= cmd.addr_bad;
    end

    assign cfg_err = err_q;

    xbar_link_query #(
        .NPORTS  (NPORTS),
        .AW      (AW),
        .HI_PORT (HI_PORT)
    ) u_query (
        .cells_i   (cell_q),
        .qa_i      (qry_a),
        .qb_i      (qry_b),
        .rd_row_i  (rd_row),
        .linked_o  (qry_linked),
        .rd_bits_o (rd_bits)
    );

endmodule

// File: rtl/xbar_cfg_matrix_chk.sv
// Module: xbar_cfg_matrix_chk
// Temporal checks on the configure port against the stored cell array.
// Bound to every xbar_cfg_matrix instance.
module xbar_cfg_matrix_chk #(
    parameter int NPORTS  = 16,
    parameter int AW      = 4,
    parameter int HI_PORT = 13
) (
    input logic                          clk,
    input logic                          rst_n,
    input logic                          cfg_valid,
    input logic [2:0]                    cfg_ctrl,
    input logic [AW-1:0]                 cfg_row,
    input logic [AW-1:0]                 cfg_col,
    input logic                          cfg_err,
    input logic [NPORTS-1:0][NPORTS-1:0] cells
);

    localparam logic [AW-1:0] HI_ADDR = AW'(HI_PORT);

    logic fast_op;
    logic good_op;
    logic bad_op;

    // Classify the current operation independently of the decoder.
    always_comb begin
        fast_op = cfg_valid && (cfg_ctrl[2] == 1'b0);
        good_op = fast_op && !(cfg_row > HI_ADDR) && !(cfg_col > HI_ADDR);
        bad_op  = fast_op && ((cfg_row > HI_ADDR) || (cfg_col > HI_ADDR));
    end

    assert_reset_clear_R1: assert property (@(posedge clk)
        !rst_n |=> cells == '0);

    assert_cell_written_R2: assert property (@(posedge clk) disable iff (!rst_n)
        good_op |=> cells[$past(cfg_row)][$past(cfg_col)] == $past(cfg_ctrl[0]));

    // Covers R4 and R5: a row-clearing op leaves at most the written bit.
    assert_row_wipe_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (good_op && !cfg_ctrl[1]) |=>
            $countones(cells[$past(cfg_row)]) == ($past(cfg_ctrl[0]) ? 1 : 0));

    assert_sel_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_valid && cfg_ctrl[2]) |=> ($stable(cells) && !cfg_err));

    assert_err_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
        bad_op |=> (cfg_err && $stable(cells)));

    assert_err_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !bad_op |=> !cfg_err);

    assert_idle_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_valid |=> $stable(cells));

endmodule

bind xbar_cfg_matrix xbar_cfg_matrix_chk #(
    .NPORTS  (NPORTS),
    .AW      (AW),
    .HI_PORT (HI_PORT)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .cfg_valid (cfg_valid),
    .cfg_ctrl  (cfg_ctrl),
    .cfg_row   (cfg_row),
    .cfg_col   (cfg_col),
    .cfg_err   (cfg_err),
    .cells     (cell_q)
);

// File: tb/xbar_cfg_matrix_tb.sv
// Scoreboard bench: the driver applies one operation per cycle, updates a
// reference model and queues the expected post-edge results; the monitor
// pops and compares them at the following falling edge.
module xbar_cfg_matrix_tb;

    localparam int N  = 16;
    localparam int AW = 4;
    localparam int HI = 13;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cfg_valid = 1'b0;
    logic [2:0]    cfg_ctrl = 3'b000;
    logic [AW-1:0] cfg_row = '0;
    logic [AW-1:0] cfg_col = '0;
    logic          cfg_err;
    logic [AW-1:0] qry_a = '0;
    logic [AW-1:0] qry_b = '0;
    logic          qry_linked;
    logic [AW-1:0] rd_row = '0;
    logic [N-1:0]  rd_bits;

    always #4 clk = ~clk;  // 125 MHz

    xbar_cfg_matrix #(.NPORTS(N), .AW(AW), .HI_PORT(HI)) u_dut (
        .clk(clk), .rst_n(rst_n), .cfg_valid(cfg_valid), .cfg_ctrl(cfg_ctrl),
        .cfg_row(cfg_row), .cfg_col(cfg_col), .cfg_err(cfg_err),
        .qry_a(qry_a), .qry_b(qry_b), .qry_linked(qry_linked),
        .rd_row(rd_row), .rd_bits(rd_bits)
    );

    logic [N-1:0] mdl [N];
    string        q_tag  [$];
    logic [N-1:0] q_bits [$];
    logic         q_err  [$];
    logic         q_link [$];
    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    task automatic chk(input string tag, input logic [N-1:0] act, input logic [N-1:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic link_of(input int a, input int b);
        if (a > HI || b > HI) return 1'b0;
        return mdl[a][b] | mdl[b][a];
    endfunction

    // Driver: one cycle, one operation; queue expected post-edge values.
    task automatic cyc(input bit v, input logic [2:0] c, input int r, input int col,
                       input int rr, input int qa, input int qb, input string tag);
        logic old_link;
        bit   acc;
        bit   bad;
        @(negedge clk);
        #1;
        cfg_valid = v;
        cfg_ctrl  = c;
        cfg_row   = r[AW-1:0];
        cfg_col   = col[AW-1:0];
        rd_row    = rr[AW-1:0];
        qry_a     = qa[AW-1:0];
        qry_b     = qb[AW-1:0];
        old_link  = link_of(qa, qb);
        acc = v && !c[2] && r <= HI && col <= HI;
        bad = v && !c[2] && (r > HI || col > HI);
        if (acc) begin
            if (!c[1]) mdl[r] = '0;
            mdl[r][col] = c[0];
        end
        q_tag.push_back(tag);
        q_bits.push_back(mdl[rr]);
        q_err.push_back(bad);
        q_link.push_back(link_of(qa, qb));
        #1;
        chk({"R9 pre-edge query / ", tag}, N'(qry_linked), N'(old_link));
    endtask

    task automatic idle(input int rr, input int qa, input int qb, input string tag);
        cyc(1'b0, 3'b000, 0, 0, rr, qa, qb, tag);
    endtask

    // Monitor: compare design outputs after each edge with queued items.
    initial begin
        forever begin
            @(negedge clk);
            if (q_tag.size() > 0) begin
                string        t;
                logic [N-1:0] b;
                logic         e;
                logic         l;
                t = q_tag.pop_front();
                b = q_bits.pop_front();
                e = q_err.pop_front();
                l = q_link.pop_front();
                chk({t, " R10 row"}, rd_bits, b);
                chk({t, " err"}, N'(cfg_err), N'(e));
                chk({t, " R9 link"}, N'(qry_linked), N'(l));
            end
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_chk++;
            n_fail++;
            $display("FAIL R10 watchdog: actual=running expected=finished");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < N; i++) mdl[i] = '0;
        repeat (3) @(negedge clk);
        #1 rst_n = 1'b1;

        // R1: all rows empty after reset
        for (int i = 0; i < N; i++) idle(i, i, (i + 1) % N, "R1 reset row");

        // R2: make connections, mirrored query
        cyc(1, 3'b011, 3, 5, 3, 5, 3, "R2 make 3-5");
        cyc(1, 3'b011, 3, 7, 3, 3, 7, "R2 make 3-7");
        cyc(1, 3'b011, 9, 3, 9, 3, 9, "R2 make 9-3");
        idle(3, 3, 9, "R2 row3 hold");

        // R3: break one cell
        cyc(1, 3'b010, 3, 5, 3, 5, 3, "R3 break 3-5");
        idle(9, 7, 3, "R3 others kept");

        // R4: make with row clear replaces the connection
        cyc(1, 3'b001, 3, 2, 3, 2, 3, "R4 replace 3->2");
        idle(9, 7, 3, "R4 other row kept");

        // R5: break with row clear
        cyc(1, 3'b011, 9, 0, 9, 0, 9, "R5 setup 9-0");
        cyc(1, 3'b011, 9, 13, 9, 13, 9, "R5 setup 9-13 (limit)");
        cyc(1, 3'b000, 9, 4, 9, 9, 13, "R5 clear row9");
        idle(3, 2, 3, "R5 row3 kept");

        // R6: select bit set, including a bad address
        cyc(1, 3'b111, 3, 10, 3, 3, 10, "R6 code111");
        cyc(1, 3'b100, 3, 2, 3, 2, 3, "R6 code100");
        cyc(1, 3'b101, 15, 15, 15, 2, 3, "R6 bad addr no err");
        idle(3, 2, 3, "R6 after");

        // R8: strobe low
        cyc(0, 3'b011, 4, 4, 4, 4, 4, "R8 no strobe");
        idle(4, 4, 4, "R8 after");

        // R7: out-of-range addresses
        cyc(1, 3'b011, 14, 1, 14, 14, 1, "R7 bad row");
        idle(14, 1, 14, "R7 err drops");
        cyc(1, 3'b001, 3, 15, 3, 2, 3, "R7 bad col");
        cyc(1, 3'b001, 3, 15, 3, 2, 3, "R7 bad col again");
        idle(3, 2, 3, "R7 row kept");
        cyc(1, 3'b011, 13, 13, 13, 13, 13, "R7 limit accepted");

        // R4/R9: back-to-back replacements, query the new pair each time
        for (int p = 0; p <= HI; p++)
            cyc(1, 3'b001, p, HI - p, p, HI - p, p, "R4 sweep");
        for (int p = 0; p <= HI; p++)
            cyc(1, 3'b000, p, 0, p, p, HI - p, "R5 sweep");
        idle(0, 0, 0, "R5 end");

        repeat (3) @(negedge clk);
        if (!done) begin
            done = 1'b1;
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

endmodule